// File: doc/BRIEF.md
# Set-Associative Data Cache Timing Model

This block models the timing of a data cache that sits beside a pipelined core. Each request carries a byte address and an identifier chosen by the requester. The block checks the address against its line tags, decides whether the access hits or misses, and later returns the identifier on a response channel. A hit returns after a fixed hit latency. A miss returns after a fixed memory latency. No data moves through the block. Loads and stores look the same to it: there is no opcode input. Because the write policy is write-through, a line is never dirty and an eviction costs nothing.

Lines are 64 bytes. The number of sets is the cache size in bytes divided by the associativity and then by 64, and it must be a power of two. Within a set, the line that goes longest without a touch is the one replaced. A miss claims its line as soon as the request is accepted. It also claims a slot in a table of outstanding misses, and that table is sized like the core's reorder buffer. When every slot is busy, the request port stops accepting. A perfect-mode input turns every access into a hit and leaves the stored lines alone. Two counters report the number of hits and the number of misses.

Top module: `dcache_timing`

## Requirements
- R1: Address bits [5:0] select a byte within a line and do not affect line identity. The set index is the next log2(SETS) bits, and SETS = CACHE_BYTES / WAYS / 64.
- R2: A request that hits and is accepted in cycle c raises `hitRspValid` with its `reqTag` on `hitRspTag` in cycle c + HIT_LAT, for exactly one cycle.
- R3: A request that misses and is accepted in cycle c raises `missRspValid` with its tag on `missRspTag` in cycle c + MISS_LAT, for exactly one cycle.
- R4: A miss installs its line when it is accepted. A later access to the same line hits with hit latency, even while the first miss is still outstanding.
- R5: Within a set, a miss fills an empty way if one exists. Otherwise it evicts the line that has gone longest without being accessed. Every access makes its line the most recently used.
- R6: While `perfectMode` is 1, every accepted request is a hit with hit latency and the stored lines are left unchanged. A line touched only in perfect mode still misses later.
- R7: `hitCount` and `missCount` start at 0 and each adds one, in the cycle after acceptance, for every accepted hit or miss respectively.
- R8: A request is accepted only in a cycle where both `reqValid` and `reqReady` are 1. `reqReady` is 0 exactly when MSHR_DEPTH misses are outstanding. A miss counts as outstanding from the cycle after it is accepted through its response cycle.
- R9: After reset, no response is valid, `reqReady` is 1, both counters are 0 and every line is invalid.
- R10: Outstanding misses proceed independently. They respond in acceptance order, at most one per cycle, and a hit response and a miss response may appear in the same cycle on their separate channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| perfectMode | input | 1 | Forces every access to hit |
| reqValid | input | 1 | Request present |
| reqAddr | input | ADDR_W | Request byte address |
| reqTag | input | REQ_TAG_W | Requester identifier |
| reqReady | output | 1 | Block can accept a request |
| hitRspValid | output | 1 | Hit response strobe |
| hitRspTag | output | REQ_TAG_W | Identifier of the hit being answered |
| missRspValid | output | 1 | Miss response strobe |
| missRspTag | output | REQ_TAG_W | Identifier of the miss being answered |
| hitCount | output | CNT_W | Accepted hits |
| missCount | output | CNT_W | Accepted misses |

## Verification
The bench keeps its own recency-ordered list of lines for each set. It goes after several cases:
- A line that was touched again just before an eviction. A design with a broken age update would evict that line and report a false miss.
- A second access to a line whose miss is still in flight. A design that fills only on return would report two misses.
- Perfect-mode accesses. A design that fills lines during them would turn a later miss into a hit.
- A burst of misses that fills the miss table. A design that mishandles it would either drop ready one cycle late, or accept a request while full and shift every later response.

// File: rtl/dcache_pkg.sv
package dcache_pkg;
  localparam int LINE_OFF_W = 6;

  typedef struct packed {
    logic touch;
    logic fill;
  } tagStrobe_t;
endpackage

// File: rtl/dcache_tag_store.sv
module dcache_tag_store
  import dcache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SETS   = 4,
  parameter int WAYS   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] lookupAddr,
  input  tagStrobe_t        strobe,
  output logic              lookupHit
);
  localparam int IDX_W  = $clog2(SETS);
  localparam int WAY_W  = $clog2(WAYS);
  localparam int LTAG_W = ADDR_W - LINE_OFF_W - IDX_W;
  localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);

  logic [SETS-1:0][WAYS-1:0]             validMem;
  logic [SETS-1:0][WAYS-1:0][LTAG_W-1:0] tagMem;
  logic [SETS-1:0][WAYS-1:0][WAY_W-1:0]  ageMem;

  logic [IDX_W-1:0]  setIdx;
  logic [LTAG_W-1:0] lineTag;
  logic [WAYS-1:0]   wayMatch;
  logic [WAY_W-1:0]  hitWay;
  logic [WAY_W-1:0]  victimWay;
  logic [WAY_W-1:0]  touchWay;

  assign setIdx  = lookupAddr[LINE_OFF_W +: IDX_W];
  assign lineTag = lookupAddr[ADDR_W-1 -: LTAG_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_match
    assign wayMatch[w] = validMem[setIdx][w] && (tagMem[setIdx][w] == lineTag);
  end

  assign lookupHit = |wayMatch;

  always_comb begin
    hitWay = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (wayMatch[w]) hitWay = WAY_W'(w);
    end
    victimWay = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (ageMem[setIdx][w] == OLDEST) victimWay = WAY_W'(w);
    end
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!validMem[setIdx][w]) victimWay = WAY_W'(w);
    end
    touchWay = lookupHit ? hitWay : victimWay;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          validMem[s][w] <= 1'b0;
          tagMem[s][w]   <= '0;
          ageMem[s][w]   <= WAY_W'(w);
        end
      end
    end else if (strobe.touch) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touchWay) begin
          ageMem[setIdx][w] <= '0;
        end else if (ageMem[setIdx][w] < ageMem[setIdx][touchWay]) begin
          ageMem[setIdx][w] <= ageMem[setIdx][w] + 1'b1;
        end
      end
      if (strobe.fill) begin
        validMem[setIdx][touchWay] <= 1'b1;
        tagMem[setIdx][touchWay]   <= lineTag;
      end
    end
  end

  AST_FILL_ON_MISS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fill |-> !lookupHit); // R4

  AST_MRU_ON_TOUCH: assert property (@(posedge clk) disable iff (!rstN)
    strobe.touch |=> ageMem[$past(setIdx)][$past(touchWay)] == '0); // R5
endmodule

// File: rtl/dcache_ctrl.sv
module dcache_ctrl
  import dcache_pkg::*;
#(
  parameter int REQ_TAG_W   = 6,
  parameter int HIT_LAT     = 5,
  parameter int MISS_LAT    = 100,
  parameter int MSHR_DEPTH  = 16,
  parameter int CNT_W       = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 perfectMode,
  input  logic                 reqValid,
  input  logic [REQ_TAG_W-1:0] reqTag,
  input  logic                 lookupHit,
  output tagStrobe_t           strobe,
  output logic                 reqReady,
  output logic                 hitRspValid,
  output logic [REQ_TAG_W-1:0] hitRspTag,
  output logic                 missRspValid,
  output logic [REQ_TAG_W-1:0] missRspTag,
  output logic [CNT_W-1:0]     hitCount,
  output logic [CNT_W-1:0]     missCount
);
  localparam int SLOT_W = $clog2(MSHR_DEPTH);
  localparam int LAT_W  = $clog2(MISS_LAT + 1);
  localparam logic [LAT_W-1:0] LAT_INIT = LAT_W'(MISS_LAT - 1);

  logic accept;
  logic isHit;

  assign accept       = reqValid && reqReady;
  assign isHit        = perfectMode || lookupHit;
  assign strobe.touch = accept && !perfectMode;
  assign strobe.fill  = accept && !perfectMode && !lookupHit;

  // hit delay line
  logic [HIT_LAT-1:0]                pipeValid;
  logic [HIT_LAT-1:0][REQ_TAG_W-1:0] pipeTag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pipeValid <= '0;
      pipeTag   <= '0;
    end else begin
      pipeValid[0] <= accept && isHit;
      pipeTag[0]   <= reqTag;
      for (int k = 1; k < HIT_LAT; k++) begin
        pipeValid[k] <= pipeValid[k-1];
        pipeTag[k]   <= pipeTag[k-1];
      end
    end
  end

  assign hitRspValid = pipeValid[HIT_LAT-1];
  assign hitRspTag   = pipeTag[HIT_LAT-1];

  // outstanding-miss table
  logic [MSHR_DEPTH-1:0]                entValid;
  logic [MSHR_DEPTH-1:0]                entDone;
  logic [MSHR_DEPTH-1:0][REQ_TAG_W-1:0] entTag;
  logic [MSHR_DEPTH-1:0][LAT_W-1:0]     entCnt;
  logic [SLOT_W-1:0]                    allocIdx;
  logic                                 allocFire;

  assign allocFire = accept && !isHit;
  assign reqReady  = ~&entValid;

  always_comb begin
    allocIdx = '0;
    for (int i = MSHR_DEPTH - 1; i >= 0; i--) begin
      if (!entValid[i]) allocIdx = SLOT_W'(i);
    end
  end

  for (genvar i = 0; i < MSHR_DEPTH; i++) begin : g_slot
    assign entDone[i] = entValid[i] && (entCnt[i] == '0);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        entValid[i] <= 1'b0;
        entTag[i]   <= '0;
        entCnt[i]   <= '0;
      end else if (allocFire && (allocIdx == SLOT_W'(i))) begin
        entValid[i] <= 1'b1;
        entTag[i]   <= reqTag;
        entCnt[i]   <= LAT_INIT;
      end else if (entDone[i]) begin
        entValid[i] <= 1'b0;
      end else if (entValid[i]) begin
        entCnt[i] <= entCnt[i] - 1'b1;
      end
    end
  end

  always_comb begin
    missRspTag = '0;
    for (int i = 0; i < MSHR_DEPTH; i++) begin
      if (entDone[i]) missRspTag = missRspTag | entTag[i];
    end
  end

  assign missRspValid = |entDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hitCount  <= '0;
      missCount <= '0;
    end else if (accept) begin
      if (isHit) hitCount  <= hitCount + 1'b1;
      else       missCount <= missCount + 1'b1;
    end
  end

  AST_ONE_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(entDone)); // R10

  AST_MISS_ALLOC: assert property (@(posedge clk) disable iff (!rstN)
    allocFire |=> ($countones(entValid) ==
                   $past($countones(entValid)) + 1 - ($past(missRspValid) ? 1 : 0))); // R8

  AST_PERFECT_NO_MISS: assert property (@(posedge clk) disable iff (!rstN)
    (perfectMode && accept) |=> $stable(missCount)); // R6
endmodule

// File: rtl/dcache_timing.sv
module dcache_timing
  import dcache_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int CACHE_BYTES = 1024,
  parameter int WAYS        = 4,
  parameter int HIT_LAT     = 5,
  parameter int MISS_LAT    = 100,
  parameter int MSHR_DEPTH  = 16,
  parameter int REQ_TAG_W   = 6,
  parameter int CNT_W       = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 perfectMode,
  input  logic                 reqValid,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [REQ_TAG_W-1:0] reqTag,
  output logic                 reqReady,
  output logic                 hitRspValid,
  output logic [REQ_TAG_W-1:0] hitRspTag,
  output logic                 missRspValid,
  output logic [REQ_TAG_W-1:0] missRspTag,
  output logic [CNT_W-1:0]     hitCount,
  output logic [CNT_W-1:0]     missCount
);
  localparam int SETS = CACHE_BYTES / WAYS / (1 << LINE_OFF_W);

  tagStrobe_t strobe;
  logic       lookupHit;

  dcache_tag_store #(
    .ADDR_W (ADDR_W),
    .SETS   (SETS),
    .WAYS   (WAYS)
  ) uTagStore (
    .clk        (clk),
    .rstN       (rstN),
    .lookupAddr (reqAddr),
    .strobe     (strobe),
    .lookupHit  (lookupHit)
  );

  dcache_ctrl #(
    .REQ_TAG_W  (REQ_TAG_W),
    .HIT_LAT    (HIT_LAT),
    .MISS_LAT   (MISS_LAT),
    .MSHR_DEPTH (MSHR_DEPTH),
    .CNT_W      (CNT_W)
  ) uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .perfectMode  (perfectMode),
    .reqValid     (reqValid),
    .reqTag       (reqTag),
    .lookupHit    (lookupHit),
    .strobe       (strobe),
    .reqReady     (reqReady),
    .hitRspValid  (hitRspValid),
    .hitRspTag    (hitRspTag),
    .missRspValid (missRspValid),
    .missRspTag   (missRspTag),
    .hitCount     (hitCount),
    .missCount    (missCount)
  );
endmodule

// File: tb/dcache_timing_test.sv
`timescale 1ns/1ps
module dcache_timing_test;
  localparam int ADDR_W = 32;
  localparam int BYTES  = 1024;
  localparam int WAYS   = 4;
  localparam int HLAT   = 5;
  localparam int MLAT   = 100;
  localparam int DEPTH  = 8;
  localparam int TW     = 6;
  localparam int CW     = 32;
  localparam int SETS   = BYTES / WAYS / 64;
  localparam int IDXW   = $clog2(SETS);
  localparam int RING   = 256;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic perfectMode = 1'b0;
  logic reqValid = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [TW-1:0] reqTag = '0;
  logic reqReady, hitRspValid, missRspValid;
  logic [TW-1:0] hitRspTag, missRspTag;
  logic [CW-1:0] hitCount, missCount;

  always #2 clk = ~clk;

  dcache_timing #(
    .ADDR_W(ADDR_W), .CACHE_BYTES(BYTES), .WAYS(WAYS), .HIT_LAT(HLAT),
    .MISS_LAT(MLAT), .MSHR_DEPTH(DEPTH), .REQ_TAG_W(TW), .CNT_W(CW)
  ) uut (
    .clk(clk), .rstN(rstN), .perfectMode(perfectMode), .reqValid(reqValid),
    .reqAddr(reqAddr), .reqTag(reqTag), .reqReady(reqReady),
    .hitRspValid(hitRspValid), .hitRspTag(hitRspTag),
    .missRspValid(missRspValid), .missRspTag(missRspTag),
    .hitCount(hitCount), .missCount(missCount)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  int unsigned cyc = 0;
  int occ = 0;
  longint expHits = 0;
  longint expMisses = 0;
  string phaseReq = "R9";
  logic [TW-1:0] nextTag = '0;

  bit            expHV [RING];
  bit            expMV [RING];
  logic [TW-1:0] expHT [RING];
  logic [TW-1:0] expMT [RING];

  longint lineList [SETS][WAYS];
  int     lineCnt  [SETS];

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic logic [ADDR_W-1:0] mkAddr(input int lt, input int st, input int off);
    return ADDR_W'((lt << (6 + IDXW)) | ((st % SETS) << 6) | (off % 64));
  endfunction

  // recency list per set: index 0 is most recent
  function automatic bit modelAccess(input logic [ADDR_W-1:0] a);
    longint lt = longint'(a >> (6 + IDXW));
    int st = int'((a >> 6) % SETS);
    int pos = -1;
    for (int k = 0; k < lineCnt[st]; k++) if (lineList[st][k] == lt) pos = k;
    if (pos >= 0) begin
      for (int k = pos; k > 0; k--) lineList[st][k] = lineList[st][k-1];
      lineList[st][0] = lt;
      return 1'b1;
    end
    pos = (lineCnt[st] < WAYS) ? lineCnt[st] : WAYS - 1;
    for (int k = pos; k > 0; k--) lineList[st][k] = lineList[st][k-1];
    lineList[st][0] = lt;
    if (lineCnt[st] < WAYS) lineCnt[st]++;
    return 1'b0;
  endfunction

  task automatic step(input bit v, input logic [ADDR_W-1:0] a, input bit pm, output bit acc);
    int idx;
    bit hit;
    int newMiss;
    @(negedge clk);
    idx = int'(cyc % RING);
    check("R8", "reqReady", longint'(reqReady), longint'(occ < DEPTH));
    check({"R2/", phaseReq}, "hitRspValid", longint'(hitRspValid), longint'(expHV[idx]));
    if (expHV[idx]) check({"R2/", phaseReq}, "hitRspTag", longint'(hitRspTag), longint'(expHT[idx]));
    check({"R3/", phaseReq}, "missRspValid", longint'(missRspValid), longint'(expMV[idx]));
    if (expMV[idx]) check({"R3/R10"}, "missRspTag", longint'(missRspTag), longint'(expMT[idx]));
    check("R7", "hitCount", longint'(hitCount), expHits);
    check("R7", "missCount", longint'(missCount), expMisses);
    reqValid = v;
    reqAddr = a;
    perfectMode = pm;
    reqTag = nextTag;
    #1;
    acc = v && reqReady;
    newMiss = 0;
    if (acc) begin
      hit = pm ? 1'b1 : modelAccess(a);
      if (hit) begin
        expHV[(idx + HLAT) % RING] = 1'b1;
        expHT[(idx + HLAT) % RING] = nextTag;
        expHits++;
      end else begin
        expMV[(idx + MLAT) % RING] = 1'b1;
        expMT[(idx + MLAT) % RING] = nextTag;
        expMisses++;
        newMiss = 1;
      end
      nextTag = nextTag + 1'b1;
    end
    occ = occ + newMiss - (expMV[idx] ? 1 : 0);
    expHV[idx] = 1'b0;
    expMV[idx] = 1'b0;
    cyc++;
  endtask

  task automatic issue(input logic [ADDR_W-1:0] a, input bit pm);
    bit acc = 0;
    while (!acc) step(1'b1, a, pm, acc);
  endtask

  task automatic idle(input int n);
    bit acc;
    for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0, acc);
  endtask

  initial begin
    bit acc;
    bit pend = 0;
    logic [ADDR_W-1:0] pa = '0;
    bit ppm = 0;
    void'($urandom(32'd2024));
    for (int i = 0; i < RING; i++) begin
      expHV[i] = 0; expMV[i] = 0; expHT[i] = '0; expMT[i] = '0;
    end
    for (int s = 0; s < SETS; s++) lineCnt[s] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R9: reset state
    #1;
    check("R9", "reqReady after reset", longint'(reqReady), 1);
    check("R9", "hitCount after reset", longint'(hitCount), 0);
    check("R9", "missCount after reset", longint'(missCount), 0);
    check("R9", "responses after reset", longint'(hitRspValid | missRspValid), 0);

    // R9 + R4 + R1: cold miss, then same line at other offsets hits while miss in flight
    phaseReq = "R4";
    issue(mkAddr(3, 0, 0), 1'b0);
    phaseReq = "R1";
    issue(mkAddr(3, 0, 40), 1'b0);
    issue(mkAddr(3, 0, 63), 1'b0);
    issue(mkAddr(3, 1, 40), 1'b0);
    idle(MLAT + 2);

    // R5: LRU order within set 2
    phaseReq = "R5";
    for (int t = 20; t < 24; t++) issue(mkAddr(t, 2, t), 1'b0);
    issue(mkAddr(20, 2, 1), 1'b0);
    issue(mkAddr(24, 2, 0), 1'b0);
    issue(mkAddr(21, 2, 0), 1'b0);
    issue(mkAddr(20, 2, 0), 1'b0);
    issue(mkAddr(23, 2, 0), 1'b0);
    issue(mkAddr(22, 2, 0), 1'b0);
    idle(MLAT + 2);

    // R6: perfect mode hits and leaves lines untouched
    phaseReq = "R6";
    issue(mkAddr(50, 3, 0), 1'b1);
    issue(mkAddr(20, 2, 0), 1'b1);
    idle(HLAT + 1);
    issue(mkAddr(50, 3, 8), 1'b0);
    idle(MLAT + 2);

    // R8 + R10: burst of misses beyond table capacity, mixed with a hit
    phaseReq = "R10";
    for (int t = 0; t < DEPTH + 3; t++) issue(mkAddr(100 + t, t, 0), 1'b0);
    phaseReq = "R8";
    issue(mkAddr(100, 0, 5), 1'b0);
    idle(MLAT + 2);

    // random traffic
    phaseReq = "R5/R10";
    for (int n = 0; n < 3000; n++) begin
      if (!pend) begin
        pend = ($urandom % 10) < 4;
        pa = mkAddr(int'($urandom % 6), int'($urandom % SETS), int'($urandom % 64));
        ppm = ($urandom % 16) == 0;
      end
      step(pend, pa, ppm, acc);
      if (acc) pend = 0;
    end
    idle(MLAT + 4);
    check("R7", "final hitCount", longint'(hitCount), expHits);
    check("R7", "final missCount", longint'(missCount), expMisses);
    check("R8", "ready when drained", longint'(reqReady), 1);

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog run did not complete actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule